// File: doc/BRIEF.md
# BCD Calendar Counter with Week Numbering

This block is the timekeeping core of a low-power clock. It counts enable pulses from a 32768 Hz oscillator in a binary prescaler and derives a one-second tick. Each tick advances a packed BCD calendar that holds seconds, minutes, hours, day of month, month, two-digit year, weekday and week number. The day rollover follows the Gregorian month lengths. February has 29 days in every year divisible by four. The week number moves only when the weekday wraps, and it has a special rollover at the end of the year.

A host loads all eight fields at once through a single 64-bit word, and it reads them back through a word with the same layout. Two test controls are provided. One makes the tick 32 times faster. The other turns the calendar into eight independent counters that each step once per tick, with no carries between them. The prescaler also brings out a 256 Hz square wave so that the crystal frequency can be measured.

Top module: `bcd_calendar_core`

## Requirements
- R1: On synchronous reset, all fields become their minimum: seconds, minutes, hours, year and week are 00, and day, month and weekday are 01. In the 64-bit word this is 64'h0001_0001_0100_0000.
- R2: Word layout, with the least significant byte first: bits [7:0] seconds, [15:8] minutes, [23:16] hours, [31:24] day, [39:32] month, [47:40] year, [55:48] weekday (1 is Monday), [63:56] week. When `load_en` is high, the whole word is taken on the next edge, and it takes priority over any tick in that cycle.
- R3: In normal mode, one tick occurs every 2^DIV_BITS cycles in which `osc_tick` is high. Seconds and minutes wrap from 59 to 00 and hours wrap from 23 to 00. Each wrap advances the next field.
- R4: When the hours wrap, the day advances, up to the length of the current month. February has 29 days when (10*tens + units) of the year is divisible by 4, and 28 days otherwise. April, June, September and November have 30 days, and every other month has 31.
- R5: When the day wraps, the month advances. When the month wraps from 12 to 01, the year advances, and the year wraps from 99 to 00.
- R6: When the hours wrap, the weekday advances from 1 to 7 and back to 1. The week changes only on the wrap from 7 to 1. On that wrap it counts up in BCD from 00 to 52.
- R7: When week 52 ends on a weekday-7 day dated 25, 26 or 27 December, the next week is 00. When week 52 ends on any other date, the next week is 01.
- R8: A field that holds an out-of-range value or a non-BCD digit is set to its minimum on its next increment, and it produces no carry. When the month is out of range, the day uses a 31-day limit.
- R9: With `test_fast` high, a tick occurs every 2^DIV_BITS/32 enabled cycles.
- R10: With `test_parallel` high, every field steps by one on each tick and wraps to its minimum after its maximum. The fields do not carry into each other, and the day maximum is 31.
- R11: `meas_tap` is a 50% square wave. Its period is 2^(DIV_BITS-8) enabled cycles, which gives 256 Hz from 32768 Hz.
- R12: While `osc_tick` is low, neither the calendar nor the prescaler changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One pulse per oscillator period |
| load_en | input | 1 | Load all fields from load_word |
| load_word | input | 64 | Packed BCD fields to load |
| test_fast | input | 1 | Accelerate the tick by 32 |
| test_parallel | input | 1 | Independent per-field increment |
| time_word | output | 64 | Packed BCD current fields |
| meas_tap | output | 1 | 256 Hz measurement square wave |

## Verification
Single-tick patterns are loaded just before each rollover boundary: the ends of 30-day months, February in leap and common years, and the end of the year. Comparing their results separates the day-limit logic from the month and year carries. Week-52 loads dated both inside and outside the 25-27 December window tell the two week rollover targets apart. Loads with illegal values show that clearing happens without a carry. Runs in the fast and parallel modes, alone and together, each last exactly one base period; the number of steps then gives the tick ratio, and the multi-wrap values reached show that no carry passes between fields. Throughout, a behavioural model checks the outputs on every cycle.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef struct packed {
        logic [7:0] week;
        logic [7:0] wday;
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] mday;
        logic [7:0] hours;
        logic [7:0] mins;
        logic [7:0] secs;
    } cal_t;

    typedef struct packed {
        logic [7:0] val;
        logic       carry;
    } bcd_step_t;

    localparam int FAST_SHIFT = 5;
    localparam cal_t CAL_RESET = '{week: 8'h00, wday: 8'h01, year: 8'h00,
                                   month: 8'h01, mday: 8'h01, hours: 8'h00,
                                   mins: 8'h00, secs: 8'h00};

    function automatic logic digits_ok(input logic [7:0] v);
        return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
    endfunction

    function automatic logic [7:0] bcd_next(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic bcd_step_t bcd_step(input logic [7:0] v,
                                           input logic [7:0] lo,
                                           input logic [7:0] hi);
        bcd_step_t r;
        if (!digits_ok(v) || v < lo || v > hi) begin
            r.val = lo;
            r.carry = 1'b0;
        end else if (v == hi) begin
            r.val = lo;
            r.carry = 1'b1;
        end else begin
            r.val = bcd_next(v);
            r.carry = 1'b0;
        end
        return r;
    endfunction

    function automatic logic leap_year(input logic [7:0] yr);
        logic [1:0] s;
        s = yr[1:0] + {yr[4], 1'b0};
        return s == 2'd0;
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] mon,
                                             input logic [7:0] yr);
        case (mon)
            8'h02: return leap_year(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default: return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int DIV_BITS = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_tick,
    output logic sec_tick,
    output logic fast_tick,
    output logic meas_tap
);
    import cal_pkg::*;

    localparam int FAST_BITS = DIV_BITS - FAST_SHIFT;
    localparam int TAP_BIT   = DIV_BITS - 9;

    logic [DIV_BITS-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (osc_tick)
            cnt <= cnt + 1'b1;
    end

    assign sec_tick  = osc_tick & (&cnt);
    assign fast_tick = osc_tick & (&cnt[FAST_BITS-1:0]);
    assign meas_tap  = cnt[TAP_BIT];

    assert_div_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !osc_tick |=> $stable(cnt));

    assert_tick_nested_R9: assert property (@(posedge clk) disable iff (rst)
        sec_tick |-> fast_tick);

endmodule

// File: rtl/cal_next_state.sv
module cal_next_state (
    input  cal_pkg::cal_t cur,
    input  logic          parallel_mode,
    output cal_pkg::cal_t nxt
);
    import cal_pkg::*;

    bcd_step_t s_st, m_st, h_st, d_st, mo_st, y_st, wd_st, wk_st;
    bcd_step_t pd_st;
    logic      dec_window;

    assign s_st  = bcd_step(cur.secs,  8'h00, 8'h59);
    assign m_st  = bcd_step(cur.mins,  8'h00, 8'h59);
    assign h_st  = bcd_step(cur.hours, 8'h00, 8'h23);
    assign d_st  = bcd_step(cur.mday,  8'h01, month_len(cur.month, cur.year));
    assign pd_st = bcd_step(cur.mday,  8'h01, 8'h31);
    assign mo_st = bcd_step(cur.month, 8'h01, 8'h12);
    assign y_st  = bcd_step(cur.year,  8'h00, 8'h99);
    assign wd_st = bcd_step(cur.wday,  8'h01, 8'h07);
    assign wk_st = bcd_step(cur.week,  8'h00, 8'h52);

    assign dec_window = (cur.month == 8'h12) && (cur.mday >= 8'h25) && (cur.mday <= 8'h27);

    always_comb begin
        nxt = cur;
        if (parallel_mode) begin
            nxt.secs  = s_st.val;
            nxt.mins  = m_st.val;
            nxt.hours = h_st.val;
            nxt.mday  = pd_st.val;
            nxt.month = mo_st.val;
            nxt.year  = y_st.val;
            nxt.wday  = wd_st.val;
            nxt.week  = wk_st.val;
        end else begin
            nxt.secs = s_st.val;
            if (s_st.carry) begin
                nxt.mins = m_st.val;
                if (m_st.carry) begin
                    nxt.hours = h_st.val;
                    if (h_st.carry) begin
                        nxt.mday = d_st.val;
                        nxt.wday = wd_st.val;
                        if (wd_st.carry) begin
                            if (cur.week == 8'h52)
                                nxt.week = dec_window ? 8'h00 : 8'h01;
                            else
                                nxt.week = wk_st.val;
                        end
                        if (d_st.carry) begin
                            nxt.month = mo_st.val;
                            if (mo_st.carry)
                                nxt.year = y_st.val;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core #(
    parameter int DIV_BITS = 15
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        osc_tick,
    input  logic        load_en,
    input  logic [63:0] load_word,
    input  logic        test_fast,
    input  logic        test_parallel,
    output logic [63:0] time_word,
    output logic        meas_tap
);
    import cal_pkg::*;

    logic sec_tick, fast_tick, tick;
    cal_t time_q, time_nxt;

    cal_prescaler #(.DIV_BITS(DIV_BITS)) u_presc (
        .clk(clk), .rst(rst), .osc_tick(osc_tick),
        .sec_tick(sec_tick), .fast_tick(fast_tick), .meas_tap(meas_tap)
    );

    assign tick = test_fast ? fast_tick : sec_tick;

    cal_next_state u_next (
        .cur(time_q), .parallel_mode(test_parallel), .nxt(time_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            time_q <= CAL_RESET;
        else if (load_en)
            time_q <= cal_t'(load_word);
        else if (tick)
            time_q <= time_nxt;
    end

    assign time_word = time_q;

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        load_en |=> time_word == $past(load_word));

    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load_en) |=> $stable(time_q));

    assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_en && !test_parallel && time_q.secs == 8'h59)
        |=> time_q.secs == 8'h00);

    assert_week_steady_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_en && !test_parallel && time_q.wday != 8'h07)
        |=> $stable(time_q.week));

    assert_par_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_en && test_parallel && time_q.mins == 8'h59)
        |=> time_q.mins == 8'h00);

endmodule

// File: tb/bcd_calendar_core_bench.sv
module bcd_calendar_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DIVB = 10;
    localparam int BASE = 1 << DIVB;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        osc_tick = 1'b1;
    logic        load_en = 1'b0;
    logic [63:0] load_word = '0;
    logic        test_fast = 1'b0;
    logic        test_parallel = 1'b0;
    logic [63:0] time_word;
    logic        meas_tap;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_calendar_core #(.DIV_BITS(DIVB)) u_bcd_calendar_core (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .load_en(load_en),
        .load_word(load_word), .test_fast(test_fast),
        .test_parallel(test_parallel), .time_word(time_word),
        .meas_tap(meas_tap)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] mf [8];
    int mcnt;

    function automatic int bval(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] tob(input int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    function automatic logic [7:0] inc(input logic [7:0] b, input int lo,
                                       input int hi, output bit c);
        c = 0;
        if (b[7:4] > 9 || b[3:0] > 9 || bval(b) < lo || bval(b) > hi) return tob(lo);
        if (bval(b) == hi) begin c = 1; return tob(lo); end
        return tob(bval(b) + 1);
    endfunction

    function automatic int mlen(input logic [7:0] mo, input logic [7:0] yr);
        if (mo == 8'h02) return (bval(yr) % 4 == 0) ? 29 : 28;
        if (mo == 8'h04 || mo == 8'h06 || mo == 8'h09 || mo == 8'h11) return 30;
        return 31;
    endfunction

    function automatic logic [63:0] mword();
        return {mf[7], mf[6], mf[5], mf[4], mf[3], mf[2], mf[1], mf[0]};
    endfunction

    always @(posedge clk) begin
        bit c, cd, cw, t;
        logic [7:0] od, om;
        if (rst) begin
            mf[0] = 8'h00; mf[1] = 8'h00; mf[2] = 8'h00; mf[3] = 8'h01;
            mf[4] = 8'h01; mf[5] = 8'h00; mf[6] = 8'h01; mf[7] = 8'h00;
            mcnt = 0;
        end else begin
            t = 0;
            if (osc_tick) begin
                if (test_fast) t = (mcnt % (BASE / 32)) == (BASE / 32 - 1);
                else t = (mcnt == BASE - 1);
                mcnt = (mcnt + 1) % BASE;
            end
            if (load_en) begin
                for (int i = 0; i < 8; i++) mf[i] = load_word[8*i +: 8];
            end else if (t && test_parallel) begin
                mf[0] = inc(mf[0], 0, 59, c); mf[1] = inc(mf[1], 0, 59, c);
                mf[2] = inc(mf[2], 0, 23, c); mf[3] = inc(mf[3], 1, 31, c);
                mf[4] = inc(mf[4], 1, 12, c); mf[5] = inc(mf[5], 0, 99, c);
                mf[6] = inc(mf[6], 1, 7, c);  mf[7] = inc(mf[7], 0, 52, c);
            end else if (t) begin
                od = mf[3]; om = mf[4];
                mf[0] = inc(mf[0], 0, 59, c);
                if (c) begin
                    mf[1] = inc(mf[1], 0, 59, c);
                    if (c) begin
                        mf[2] = inc(mf[2], 0, 23, c);
                        if (c) begin
                            mf[3] = inc(od, 1, mlen(om, mf[5]), cd);
                            mf[6] = inc(mf[6], 1, 7, cw);
                            if (cw) begin
                                if (mf[7] == 8'h52)
                                    mf[7] = (om == 8'h12 && bval(od) >= 25 && bval(od) <= 27) ? 8'h00 : 8'h01;
                                else
                                    mf[7] = inc(mf[7], 0, 52, c);
                            end
                            if (cd) begin
                                mf[4] = inc(om, 1, 12, c);
                                if (c) mf[5] = inc(mf[5], 0, 99, c);
                            end
                        end
                    end
                end
            end
        end
    end

    // Per-cycle comparison against the model (R3 main counting function)
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (time_word !== mword()) begin
                fails++;
                $display("FAIL R3 model compare: actual %h expected %h", time_word, mword());
            end
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [63:0] mk(input logic [7:0] wk, wd, yr, mo, dy, hr, mi, se);
        return {wk, wd, yr, mo, dy, hr, mi, se};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(input logic [63:0] w);
        @(negedge clk);
        load_en = 1'b1;
        load_word = w;
        @(negedge clk);
        load_en = 1'b0;
        check("R2 load", time_word, w);
    endtask

    task automatic one_base(input string req, input logic [63:0] w, input logic [63:0] exp);
        load(w);
        repeat (BASE) @(negedge clk);
        check(req, time_word, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog expired: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int tog;
        logic prev;
        logic [63:0] snap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state", time_word, 64'h0001_0001_0100_0000);

        one_base("R5 year end", mk(8'h52, 8'h07, 8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59),
                 mk(8'h01, 8'h01, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00));
        one_base("R7 dec window", mk(8'h52, 8'h07, 8'h20, 8'h12, 8'h26, 8'h23, 8'h59, 8'h59),
                 mk(8'h00, 8'h01, 8'h20, 8'h12, 8'h27, 8'h00, 8'h00, 8'h00));
        one_base("R4 leap feb 28", mk(8'h08, 8'h04, 8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59),
                 mk(8'h08, 8'h05, 8'h24, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00));
        one_base("R4 leap feb 29", mk(8'h08, 8'h05, 8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59),
                 mk(8'h08, 8'h06, 8'h24, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00));
        one_base("R4 common feb", mk(8'h08, 8'h02, 8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59),
                 mk(8'h08, 8'h03, 8'h23, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00));
        one_base("R4 april 30", mk(8'h17, 8'h03, 8'h21, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59),
                 mk(8'h17, 8'h04, 8'h21, 8'h05, 8'h01, 8'h00, 8'h00, 8'h00));
        one_base("R6 week bcd carry", mk(8'h09, 8'h07, 8'h21, 8'h03, 8'h07, 8'h23, 8'h59, 8'h59),
                 mk(8'h10, 8'h01, 8'h21, 8'h03, 8'h08, 8'h00, 8'h00, 8'h00));
        one_base("R3 minute carry", mk(8'h05, 8'h03, 8'h21, 8'h06, 8'h15, 8'h10, 8'h59, 8'h59),
                 mk(8'h05, 8'h03, 8'h21, 8'h06, 8'h15, 8'h11, 8'h00, 8'h00));
        one_base("R8 bad seconds", mk(8'h05, 8'h03, 8'h21, 8'h06, 8'h15, 8'h10, 8'h20, 8'h75),
                 mk(8'h05, 8'h03, 8'h21, 8'h06, 8'h15, 8'h10, 8'h20, 8'h00));
        one_base("R8 bad hours", mk(8'h05, 8'h03, 8'h21, 8'h06, 8'h15, 8'h24, 8'h59, 8'h59),
                 mk(8'h05, 8'h03, 8'h21, 8'h06, 8'h15, 8'h00, 8'h00, 8'h00));
        one_base("R8 bad month", mk(8'h05, 8'h03, 8'h21, 8'h13, 8'h31, 8'h23, 8'h59, 8'h59),
                 mk(8'h05, 8'h04, 8'h21, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00));

        test_parallel = 1'b1;
        one_base("R10 parallel wrap", mk(8'h52, 8'h07, 8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59),
                 mk(8'h00, 8'h01, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00));
        one_base("R10 parallel step", mk(8'h20, 8'h03, 8'h45, 8'h06, 8'h15, 8'h12, 8'h34, 8'h56),
                 mk(8'h21, 8'h04, 8'h46, 8'h07, 8'h16, 8'h13, 8'h35, 8'h57));
        test_fast = 1'b1;
        one_base("R10 parallel fast", mk(8'h00, 8'h01, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00),
                 mk(8'h32, 8'h05, 8'h32, 8'h09, 8'h02, 8'h08, 8'h32, 8'h32));
        test_parallel = 1'b0;
        one_base("R9 fast mode", mk(8'h00, 8'h01, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00),
                 mk(8'h00, 8'h01, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h32));
        test_fast = 1'b0;

        // R11: measurement tap toggles every BASE/512 cycles
        tog = 0;
        prev = meas_tap;
        for (int i = 0; i < BASE; i++) begin
            @(negedge clk);
            if (meas_tap !== prev) tog++;
            prev = meas_tap;
        end
        check("R11 tap toggles", 64'(tog), 64'(BASE / 2));

        // R12: no oscillator enable, nothing moves
        osc_tick = 1'b0;
        snap = time_word;
        prev = meas_tap;
        repeat (3 * BASE) @(negedge clk);
        check("R12 time held", time_word, snap);
        check("R12 tap held", {63'd0, meas_tap}, {63'd0, prev});
        osc_tick = 1'b1;
        repeat (2 * BASE) @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule